// File: doc/BRIEF.md
# Single-Shot Converter Sequencer

This block runs one analog-to-digital conversion at a time on each of two converter units. Software, or an alternate low-power sequencer, picks a channel through a one-hot bitmap and raises a start bit. The block launches the conversion on the 0-to-1 edge of that start bit. It drives the pad-enable bitmap to the converter and keeps it steady until the converter reports completion. It then stores a formatted result and raises a done flag, which software polls.

Each unit has its own ownership select, result inversion, output width and converter clock divider. Ownership decides whether the software copy or the sequencer copy of the start bit and bitmap is used. One shared power field chooses between three settings: the controller manages power, power is forced on, or power is forced off. In the managed setting the converter is powered while any unit is busy and for a fixed hold time afterwards. The analog converter sits behind a plain request/done interface. The request stays high for the whole conversion, and the raw 12-bit sample is valid while done is high.

Top module: `ssadc_ctrl`

## Requirements
- R1: A conversion on unit u launches only on a 0-to-1 transition of that unit's selected start bit, sampled at a clock edge. In the cycle after that edge, `conv_req[u]` and `busy[u]` are high. Holding the start bit at 1 never launches a second conversion.
- R2: While `busy[u]` is high, the unit's slice of `pad_en` equals the bitmap captured at launch. At all other times that slice is zero.
- R3: If the selected bitmap does not have exactly one bit set (all zeros, or two or more ones), a start edge is ignored. No request is raised and `done[u]` keeps its value.
- R4: A start edge while `busy[u]` is high is ignored. The running conversion keeps its bitmap and finishes normally.
- R5: `done[u]` goes high in the cycle after the converter's done pulse is sampled while the unit is busy. `busy[u]` falls at the same time. `done[u]` clears when the next accepted launch happens.
- R6: The 2-bit width code w for a unit (bits [2u+1:2u] of `width_sel`) selects 9 + w result bits: 0→9, 1→10, 2→11, 3→12. The result is the raw sample shifted right by 3 − w and zero-extended. It is captured at completion.
- R7: When `inv_en[u]` is 1, the raw sample is complemented before the width reduction.
- R8: When `own_sw[u]` is 1, `sw_start[u]` and `sw_map` slice u are used. When it is 0, `alt_start[u]` and `alt_map` slice u are used, and the other copy has no effect.
- R9: `pwr_mode` 2'b11 forces `conv_pwr` to 1 and 2'b10 forces it to 0. With bit 1 clear, `conv_pwr` is 1 while any unit is busy and for PWR_HOLD further cycles after the last busy cycle.
- R10: `conv_clk_en[u]` pulses once every D cycles, where D is the unit's `clk_div` slice, and once every cycle when D is 0 or 1. When the divider is lowered below the current count, the next pulse comes at once.
- R11: A converter done pulse while the unit is not busy is ignored. The result and the done flag are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_sw | input | 2 | Per-unit owner select: 1 = software, 0 = alternate sequencer |
| sw_start | input | 2 | Software start bits |
| alt_start | input | 2 | Sequencer start bits |
| sw_map | input | 2*CH | Software channel bitmaps, unit u at [u*CH +: CH] |
| alt_map | input | 2*CH | Sequencer channel bitmaps |
| inv_en | input | 2 | Per-unit result inversion |
| width_sel | input | 4 | Per-unit width code, 2 bits each |
| clk_div | input | 2*DIVW | Per-unit converter clock divider |
| pwr_mode | input | 2 | Power setting: 0x managed, 10 off, 11 on |
| conv_done | input | 2 | Converter completion pulse per unit |
| conv_raw | input | 2*DW | Raw converter samples, unit u at [u*DW +: DW] |
| conv_req | output | 2 | Conversion request per unit |
| pad_en | output | 2*CH | One-hot pad enables per unit |
| conv_clk_en | output | 2 | Divided converter clock enable per unit |
| conv_pwr | output | 1 | Converter power enable |
| busy | output | 2 | Conversion in progress per unit |
| done | output | 2 | Result-ready flag per unit |
| result | output | 2*DW | Formatted result per unit |

## Verification
The assertions assume the converter pulses `conv_done` for a single cycle and only in response to a request. They also assume the power field is held steady for at least a cycle. The only exception is the idle-done check, which deliberately injects a stray pulse. The stimulus drives the converter from a bench model that answers a held request after a programmable latency and then drops its pulse. Spurious completions are injected only while the targeted unit is idle. Start bits, bitmaps and mode fields change only between clock edges, so every edge sees stable inputs.

// File: rtl/ssadc_ctrl.sv
module ssadc_ctrl #(
  parameter int CH       = 10,
  parameter int DW       = 12,
  parameter int DIVW     = 8,
  parameter int PWR_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        own_sw,
  input  logic [1:0]        sw_start,
  input  logic [1:0]        alt_start,
  input  logic [2*CH-1:0]   sw_map,
  input  logic [2*CH-1:0]   alt_map,
  input  logic [1:0]        inv_en,
  input  logic [3:0]        width_sel,
  input  logic [2*DIVW-1:0] clk_div,
  input  logic [1:0]        pwr_mode,
  input  logic [1:0]        conv_done,
  input  logic [2*DW-1:0]   conv_raw,
  output logic [1:0]        conv_req,
  output logic [2*CH-1:0]   pad_en,
  output logic [1:0]        conv_clk_en,
  output logic              conv_pwr,
  output logic [1:0]        busy,
  output logic [1:0]        done,
  output logic [2*DW-1:0]   result
);
  localparam int HW = $clog2(PWR_HOLD + 1);

  logic [HW-1:0] hold_q;

  for (genvar u = 0; u < 2; u++) begin : g_unit
    logic          start_q, busy_q, done_q, stb_q;
    logic [CH-1:0] pad_q;
    logic [DW-1:0] res_q, raw_v, fmt;
    logic [DIVW-1:0] cnt_q, div_v, lim;
    logic          eff_start, map_ok, launch, finish, wrap;
    logic [CH-1:0] eff_map;

    assign eff_start = own_sw[u] ? sw_start[u] : alt_start[u];
    assign eff_map   = own_sw[u] ? sw_map[u*CH +: CH] : alt_map[u*CH +: CH];
    assign map_ok    = (eff_map != '0) && ((eff_map & (eff_map - 1'b1)) == '0);
    assign launch    = eff_start & ~start_q & map_ok & ~busy_q;
    assign finish    = busy_q & conv_done[u];

    assign raw_v = inv_en[u] ? ~conv_raw[u*DW +: DW] : conv_raw[u*DW +: DW];
    assign fmt   = raw_v >> (2'd3 - width_sel[2*u +: 2]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q <= 1'b0;
        busy_q  <= 1'b0;
        done_q  <= 1'b0;
        pad_q   <= '0;
        res_q   <= '0;
      end else begin
        start_q <= eff_start;
        if (launch) begin
          busy_q <= 1'b1;
          done_q <= 1'b0;
          pad_q  <= eff_map;
        end else if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pad_q  <= '0;
          res_q  <= fmt;
        end
      end
    end

    assign div_v = clk_div[u*DIVW +: DIVW];
    assign lim   = (div_v == '0) ? '0 : div_v - 1'b1;
    assign wrap  = cnt_q >= lim;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        stb_q <= 1'b0;
      end else begin
        stb_q <= wrap;
        cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      end
    end

    assign conv_req[u]          = busy_q;
    assign busy[u]              = busy_q;
    assign done[u]              = done_q;
    assign pad_en[u*CH +: CH]   = pad_q;
    assign result[u*DW +: DW]   = res_q;
    assign conv_clk_en[u]       = stb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hold_q <= '0;
    else if (|busy)      hold_q <= HW'(PWR_HOLD);
    else if (hold_q != 0) hold_q <= hold_q - 1'b1;
  end

  assign conv_pwr = pwr_mode[1] ? pwr_mode[0] : ((|busy) | (hold_q != '0));
endmodule

// File: rtl/ssadc_ctrl_sva.sv
module ssadc_ctrl_sva #(
  parameter int CH = 10,
  parameter int DW = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      busy,
  input logic [1:0]      done,
  input logic [2*CH-1:0] pad_en,
  input logic [1:0]      conv_done,
  input logic [2*DW-1:0] result,
  input logic            conv_pwr,
  input logic [1:0]      pwr_mode
);
  for (genvar u = 0; u < 2; u++) begin : g_chk
    p_pad_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy[u] |-> $onehot(pad_en[u*CH +: CH]));
    p_pad_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy[u] |-> (pad_en[u*CH +: CH] == '0));
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[u] && !conv_done[u]) |=> (busy[u] && $stable(pad_en[u*CH +: CH])));
    p_launch_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[u]) |-> !done[u]);
    p_finish_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[u]) |-> done[u]);
    p_idle_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy[u] && conv_done[u]) |=> $stable(result[u*DW +: DW]));
  end

  p_pwr_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_mode[1] && (|busy)) |-> conv_pwr);
  p_pwr_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 2'b10) |-> !conv_pwr);
endmodule

bind ssadc_ctrl ssadc_ctrl_sva #(.CH(CH), .DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pad_en(pad_en),
  .conv_done(conv_done), .result(result), .conv_pwr(conv_pwr), .pwr_mode(pwr_mode)
);

// File: tb/tb_ssadc_ctrl.sv
`timescale 1ns/1ps
module tb_ssadc_ctrl;
  localparam int CH = 10, DW = 12, DIVW = 8, PWR_HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]        own_sw = 2'b11, sw_start = '0, alt_start = '0;
  logic [2*CH-1:0]   sw_map = '0, alt_map = '0;
  logic [1:0]        inv_en = '0;
  logic [3:0]        width_sel = 4'hF;
  logic [2*DIVW-1:0] clk_div = '0;
  logic [1:0]        pwr_mode = '0;
  logic [1:0]        cdone_m = '0, inj = '0, conv_done;
  logic [2*DW-1:0]   conv_raw = {12'h5A5, 12'hABC};
  logic [1:0]        conv_req, conv_clk_en, busy, done;
  logic [2*CH-1:0]   pad_en;
  logic              conv_pwr;
  logic [2*DW-1:0]   result;

  assign conv_done = cdone_m | inj;

  ssadc_ctrl #(.CH(CH), .DW(DW), .DIVW(DIVW), .PWR_HOLD(PWR_HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .own_sw(own_sw), .sw_start(sw_start), .alt_start(alt_start),
    .sw_map(sw_map), .alt_map(alt_map), .inv_en(inv_en), .width_sel(width_sel),
    .clk_div(clk_div), .pwr_mode(pwr_mode), .conv_done(conv_done), .conv_raw(conv_raw),
    .conv_req(conv_req), .pad_en(pad_en), .conv_clk_en(conv_clk_en), .conv_pwr(conv_pwr),
    .busy(busy), .done(done), .result(result));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  int lat = 3;
  int ccnt [2] = '{0, 0};

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  bit          m_busy [2], m_done [2], m_sq [2], m_stb [2];
  int          m_pad [2], m_res [2], m_cnt [2];
  int          m_hold = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int u = 0; u < 2; u++) begin
        m_busy[u] = 0; m_done[u] = 0; m_sq[u] = 0; m_stb[u] = 0;
        m_pad[u] = 0; m_res[u] = 0; m_cnt[u] = 0;
      end
      m_hold = 0;
    end else begin
      bit anyb;
      anyb = m_busy[0] || m_busy[1];
      for (int u = 0; u < 2; u++) begin
        bit es;
        logic [CH-1:0] em;
        int lim, d, w, v;
        es = own_sw[u] ? sw_start[u] : alt_start[u];
        em = own_sw[u] ? sw_map[u*CH +: CH] : alt_map[u*CH +: CH];
        if (es && !m_sq[u] && $countones(em) == 1 && !m_busy[u]) begin
          m_busy[u] = 1; m_done[u] = 0; m_pad[u] = int'(em);
        end else if (m_busy[u] && conv_done[u]) begin
          w = int'(width_sel[2*u +: 2]);
          v = int'(conv_raw[u*DW +: DW]);
          if (inv_en[u]) v = 4095 - v;
          m_res[u] = v / (1 << (3 - w));
          m_busy[u] = 0; m_done[u] = 1; m_pad[u] = 0;
        end
        m_sq[u] = es;
        d = int'(clk_div[u*DIVW +: DIVW]);
        lim = (d == 0) ? 0 : d - 1;
        m_stb[u] = (m_cnt[u] >= lim);
        m_cnt[u] = m_stb[u] ? 0 : m_cnt[u] + 1;
      end
      if (anyb) m_hold = PWR_HOLD;
      else if (m_hold > 0) m_hold = m_hold - 1;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      for (int u = 0; u < 2; u++) begin
        cmp("R1 req", conv_req[u], m_busy[u]);
        cmp("R4 busy", busy[u], m_busy[u]);
        cmp("R2 pad", pad_en[u*CH +: CH], m_pad[u]);
        cmp("R5 done", done[u], m_done[u]);
        cmp("R6 result", result[u*DW +: DW], m_res[u]);
        cmp("R10 clk_en", conv_clk_en[u], m_stb[u]);
      end
      cmp("R9 pwr", conv_pwr, pwr_mode[1] ? pwr_mode[0] : (m_busy[0] || m_busy[1] || m_hold > 0));
    end
  end

  // converter model
  always @(negedge clk) begin
    for (int u = 0; u < 2; u++) begin
      if (cdone_m[u]) cdone_m[u] <= 1'b0;
      else if (conv_req[u]) begin
        if (ccnt[u] + 1 >= lat) begin cdone_m[u] <= 1'b1; ccnt[u] = 0; end
        else ccnt[u] = ccnt[u] + 1;
      end else ccnt[u] = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  initial begin
    logic [DW-1:0] keep;
    int n0, n1;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    cmp("R4 reset busy", busy, 0);
    cmp("R5 reset done", done, 0);
    cmp("R2 reset pad", pad_en, 0);
    cmp("R6 reset result", result, 0);

    // launch on edge, 12-bit
    sw_map[CH-1:0] = 10'd1 << 2;
    sw_start[0] = 1'b1;
    tick(1);
    cmp("R1 launch busy", busy[0], 1);
    cmp("R2 pad onehot", pad_en[CH-1:0], 10'h004);
    tick(8);
    cmp("R5 done set", done[0], 1);
    cmp("R6 w3 result", result[DW-1:0], 12'hABC);
    tick(4);
    cmp("R1 level no relaunch", busy[0], 0);

    // 9-bit inverted
    width_sel[1:0] = 2'd0; inv_en[0] = 1'b1;
    sw_start[0] = 1'b0; tick(1); sw_start[0] = 1'b1; tick(1);
    cmp("R5 done cleared", done[0], 0);
    tick(8);
    cmp("R7 inverted w0", result[DW-1:0], 12'h0A8);

    // 10-bit plain
    width_sel[1:0] = 2'd1; inv_en[0] = 1'b0;
    sw_start[0] = 1'b0; tick(1); sw_start[0] = 1'b1; tick(9);
    cmp("R6 w1 result", result[DW-1:0], 12'h2AF);

    // bad bitmaps
    sw_start[0] = 1'b0; tick(1);
    sw_map[CH-1:0] = '0; sw_start[0] = 1'b1; tick(3);
    cmp("R3 zero map busy", busy[0], 0);
    cmp("R3 zero map done", done[0], 1);
    sw_start[0] = 1'b0; tick(1);
    sw_map[CH-1:0] = 10'h003; sw_start[0] = 1'b1; tick(3);
    cmp("R3 multi map busy", busy[0], 0);

    // edge while busy
    lat = 8;
    sw_start[0] = 1'b0; sw_map[CH-1:0] = 10'h001; tick(1);
    sw_start[0] = 1'b1; tick(1);
    sw_map[CH-1:0] = 10'h200; sw_start[0] = 1'b0; tick(1);
    sw_start[0] = 1'b1; tick(1);
    cmp("R4 busy kept", busy[0], 1);
    cmp("R4 pad kept", pad_en[CH-1:0], 10'h001);
    tick(10);
    cmp("R4 finished once", {busy[0], done[0]}, 2'b01);
    lat = 3;

    // alternate owner on unit 1
    own_sw[1] = 1'b0;
    sw_map[2*CH-1:CH] = 10'h002; sw_start[1] = 1'b1; tick(3);
    cmp("R8 sw ignored", busy[1], 0);
    alt_map[2*CH-1:CH] = 10'd1 << 9; alt_start[1] = 1'b1; tick(1);
    cmp("R8 alt pad", pad_en[2*CH-1], 1);
    tick(8);
    cmp("R8 alt result", result[2*DW-1:DW], 12'h5A5);

    // power
    tick(PWR_HOLD + 2);
    cmp("R9 fsm idle off", conv_pwr, 0);
    pwr_mode = 2'b11; tick(1);
    cmp("R9 forced on", conv_pwr, 1);
    pwr_mode = 2'b10; tick(1);
    cmp("R9 forced off", conv_pwr, 0);
    pwr_mode = 2'b00;
    sw_start[0] = 1'b0; tick(1); sw_start[0] = 1'b1; tick(1);
    cmp("R9 fsm on busy", conv_pwr, 1);
    tick(4 + PWR_HOLD + 2);
    cmp("R9 fsm off after hold", conv_pwr, 0);

    // both units together
    sw_start[0] = 1'b0; alt_start[1] = 1'b0; width_sel = 4'hF; tick(1);
    sw_start[0] = 1'b1; alt_start[1] = 1'b1; tick(1);
    cmp("R1 both busy", busy, 2'b11);
    tick(8);
    cmp("R5 both done", done, 2'b11);

    // stray done while idle
    keep = result[DW-1:0];
    conv_raw[DW-1:0] = 12'h123; inj[0] = 1'b1; tick(1);
    inj[0] = 1'b0; tick(1);
    cmp("R11 stray result", result[DW-1:0], keep);
    cmp("R11 stray done", done[0], 1);

    // divider
    clk_div = {8'd1, 8'd5}; tick(10);
    n0 = 0; n1 = 0;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      n0 += int'(conv_clk_en[0]); n1 += int'(conv_clk_en[1]);
    end
    cmp("R10 div5 count", n0, 6);
    cmp("R10 div1 count", n1, 30);
    clk_div[DIVW-1:0] = 8'd2; tick(6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule